// File: doc/BRIEF.md
# Impedance Calibration Search Controller

This block runs the digital side of I/O impedance calibration. A replica driver is fed a 5-bit impedance code, and an analog comparator reports whether the replica voltage matches an externally set reference. The controller starts every sweep at the top code (31) and steps down by one, waiting a programmable number of settle cycles after each change before it looks at the comparator. The comparator level passes through a two-flop synchronizer first. The first matching code is kept as the transmit result. The same sweep is then run against the receive replica.

When the receive sweep resolves, both codes and their error flags are published together, and a one-cycle completion pulse goes out. The surrounding core logic copies the published codes into the functional I/O cells. If a sweep reaches code 0 without a match, code 0 is kept for that replica and its error flag is raised. A sweep is started either by a one-shot request or by holding a continuous-mode level. In continuous mode the next sweep begins as soon as the previous one has been published.

Top module: `imp_cal_ctrl`

## Requirements
- R1: While reset is low and afterwards, until a sweep is started: drive code = 31, replica select = 0 (transmit), busy = 0, done = 0, both stored codes = 0, both error flags = 0.
- R2: When the block is idle and start_i or cont_i is high at a clock edge, busy is 1 from that edge on, the drive code is 31 and replica select is 0.
- R3: Each code is held for S+1 cycles, where S = max(settle_i, 2). The comparator level used for a code is the one seen two cycles before its evaluation edge. If there is no match, the code drops by exactly one.
- R4: When the transmit sweep finds a match, the current code becomes the pending transmit result. On the same edge replica select becomes 1 (receive) and the drive code reloads to 31.
- R5: When the receive sweep resolves, done is high for exactly one cycle and busy falls in that cycle. done appears (Ntx+Nrx)*(S+1) edges after the start edge, where N is the number of codes tried in a sweep: 32 minus the matching code, or 32 when nothing matches.
- R6: If code 0 is evaluated with no match, that replica stores code 0 and its error flag is 1. A match at code 0 stores 0 with the error flag 0.
- R7: The stored codes and error flags change only in the cycle in which done is high. At all other times they hold the previous result.
- R8: start_i is ignored while busy. A pulse during a sweep neither changes the done timing nor causes a second sweep.
- R9: While cont_i is high, a new sweep starts on the edge after done. Lowering cont_i lets the current sweep finish and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-shot sweep request, taken only when idle |
| cont_i | input | 1 | Continuous-mode level: restart after every completed sweep |
| settle_i | input | SETTLE_W | Settle cycles after each code change; values below 2 act as 2 |
| cmp_match_i | input | 1 | Asynchronous comparator output, 1 = replica matches reference |
| drive_code_o | output | CODE_W | Code driven into the replica under test |
| replica_sel_o | output | 1 | Replica under test: 0 transmit, 1 receive |
| busy_o | output | 1 | A sweep is in progress |
| done_o | output | 1 | One-cycle pulse: both results published |
| tx_code_o | output | CODE_W | Published transmit code |
| rx_code_o | output | CODE_W | Published receive code |
| tx_err_o | output | 1 | Transmit sweep reached 0 without a match |
| rx_err_o | output | 1 | Receive sweep reached 0 without a match |

## Verification
A comparator match and reaching the floor code can happen at the same evaluation. In that case the match must win, and code 0 must be stored with no error flag. Publishing the receive result and the transmit-pending capture must never be confused either. The bench models the comparator as a threshold on the driven code, sets a threshold of exactly 0 so that the match lands on the floor, and sets a negative threshold so that the floor is reached with no match. For each case it compares the published codes, the error flags and the exact done edge against values computed from the thresholds and the settle count.

// File: rtl/imp_cal_pkg.sv
package imp_cal_pkg;

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} cal_state_e;
  typedef enum logic {REP_TX = 1'b0, REP_RX = 1'b1} replica_e;

  // Settle count actually loaded: never shorter than the synchronizer depth
  function automatic int unsigned settle_span(int unsigned req, int unsigned floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

  // Cycles one sweep costs for a given number of codes tried
  function automatic int unsigned sweep_cost(int unsigned codes, int unsigned span);
    return codes * (span + 1);
  endfunction

endpackage

// File: rtl/imp_cal_sync.sv
module imp_cal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/imp_cal_settle.sv
module imp_cal_settle #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - ONE;
  end

  assign expired_o = (cnt_q == '0);

  // R3
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_val_i != '0) |=> !expired_o);
endmodule

// File: rtl/imp_cal_results.sv
module imp_cal_results #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_tx_i,
  input  logic              publish_i,
  input  logic              err_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] tx_code_o,
  output logic [CODE_W-1:0] rx_code_o,
  output logic              tx_err_o,
  output logic              rx_err_o
);
  logic [CODE_W-1:0] tx_pend_q;
  logic              tx_pend_err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_pend_q     <= '0;
      tx_pend_err_q <= 1'b0;
      tx_code_o     <= '0;
      rx_code_o     <= '0;
      tx_err_o      <= 1'b0;
      rx_err_o      <= 1'b0;
    end else begin
      if (cap_tx_i) begin
        tx_pend_q     <= code_i;
        tx_pend_err_q <= err_i;
      end
      if (publish_i) begin
        tx_code_o <= tx_pend_q;
        tx_err_o  <= tx_pend_err_q;
        rx_code_o <= code_i;
        rx_err_o  <= err_i;
      end
    end
  end

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !publish_i |=> ($stable(tx_code_o) && $stable(rx_code_o) && $stable(tx_err_o) && $stable(rx_err_o)));
  // R6
  tx_err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err_o |-> (tx_code_o == '0));
  // R6
  rx_err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_o |-> (rx_code_o == '0));
endmodule

// File: rtl/imp_cal_ctrl.sv
module imp_cal_ctrl #(
  parameter int CODE_W      = 5,
  parameter int SETTLE_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                cont_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                cmp_match_i,
  output logic [CODE_W-1:0]   drive_code_o,
  output logic                replica_sel_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [CODE_W-1:0]   tx_code_o,
  output logic [CODE_W-1:0]   rx_code_o,
  output logic                tx_err_o,
  output logic                rx_err_o
);
  import imp_cal_pkg::*;

  localparam logic [CODE_W-1:0] CODE_TOP   = '1;
  localparam logic [CODE_W-1:0] CODE_FLOOR = '0;
  localparam logic [CODE_W-1:0] CODE_ONE   = CODE_W'(1);
  localparam int unsigned       MIN_SETTLE = SYNC_STAGES;

  cal_state_e        state_q;
  replica_e          rep_q;
  logic [CODE_W-1:0] code_q;
  logic              done_q;

  // Named internal events
  logic match_s, settle_done;
  logic go_req, eval_ev, hit_ev, floor_miss_ev, step_ev, resolve_ev;
  logic tx_resolve, rx_resolve, timer_load;
  logic [SETTLE_W-1:0] settle_load;

  imp_cal_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(cmp_match_i), .sync_o(match_s)
  );

  assign settle_load = SETTLE_W'(settle_span(32'(settle_i), MIN_SETTLE));

  assign go_req        = (state_q == ST_IDLE) && (start_i || cont_i);
  assign eval_ev       = (state_q == ST_WAIT) && settle_done;
  assign hit_ev        = eval_ev && match_s;
  assign floor_miss_ev = eval_ev && !match_s && (code_q == CODE_FLOOR);
  assign step_ev       = eval_ev && !match_s && (code_q != CODE_FLOOR);
  assign resolve_ev    = hit_ev || floor_miss_ev;
  assign tx_resolve    = resolve_ev && (rep_q == REP_TX);
  assign rx_resolve    = resolve_ev && (rep_q == REP_RX);
  assign timer_load    = go_req || step_ev || tx_resolve;

  imp_cal_settle #(.W(SETTLE_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .load_i(timer_load),
    .load_val_i(settle_load), .expired_o(settle_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rep_q   <= REP_TX;
      code_q  <= CODE_TOP;
      done_q  <= 1'b0;
    end else begin
      done_q <= rx_resolve;
      if (go_req) begin
        state_q <= ST_WAIT;
        rep_q   <= REP_TX;
        code_q  <= CODE_TOP;
      end else if (step_ev) begin
        code_q <= code_q - CODE_ONE;
      end else if (tx_resolve) begin
        rep_q  <= REP_RX;
        code_q <= CODE_TOP;
      end else if (rx_resolve) begin
        state_q <= ST_IDLE;
      end
    end
  end

  imp_cal_results #(.CODE_W(CODE_W)) u_results (
    .clk(clk), .rst_n(rst_n),
    .cap_tx_i(tx_resolve), .publish_i(rx_resolve),
    .err_i(floor_miss_ev), .code_i(code_q),
    .tx_code_o(tx_code_o), .rx_code_o(rx_code_o),
    .tx_err_o(tx_err_o), .rx_err_o(rx_err_o)
  );

  assign drive_code_o  = code_q;
  assign replica_sel_o = (rep_q == REP_RX);
  assign busy_o        = (state_q == ST_WAIT);
  assign done_o        = done_q;

  // R3
  code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && $stable(replica_sel_o))
      |-> (code_q == $past(code_q) || code_q == $past(code_q) - CODE_ONE));
  // R4
  sel_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(replica_sel_o) |-> (code_q == CODE_TOP));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && replica_sel_o));
  // R2
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(start_i || cont_i) && code_q == CODE_TOP && !replica_sel_o));
endmodule

// File: tb/imp_cal_ctrl_tb.sv
module imp_cal_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 5;
  localparam int SETTLE_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic cont_i = 1'b0;
  logic [SETTLE_W-1:0] settle_i = '0;
  logic cmp_match;
  logic [CODE_W-1:0] drive_code, tx_code, rx_code;
  logic replica_sel, busy, done, tx_err, rx_err;

  int thr_tx = -1;
  int thr_rx = -1;
  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Analog model: the replica matches when its code is at or below the threshold
  assign cmp_match = replica_sel ? (thr_rx >= 0 && int'(drive_code) <= thr_rx)
                                 : (thr_tx >= 0 && int'(drive_code) <= thr_tx);

  imp_cal_ctrl #(.CODE_W(CODE_W), .SETTLE_W(SETTLE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
    .settle_i(settle_i), .cmp_match_i(cmp_match),
    .drive_code_o(drive_code), .replica_sel_o(replica_sel),
    .busy_o(busy), .done_o(done), .tx_code_o(tx_code), .rx_code_o(rx_code),
    .tx_err_o(tx_err), .rx_err_o(rx_err)
  );

  function automatic int eff_settle(int s);
    return (s < 2) ? 2 : s;
  endfunction
  function automatic int codes_tried(int thr);
    return (thr >= 0) ? 32 - thr : 32;
  endfunction
  function automatic int exp_code(int thr);
    return (thr >= 0) ? thr : 0;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called just after the edge that accepted the sweep
  task automatic measure_sweep(int s, bit poke_start);
    int span = eff_settle(s);
    int tx_edge = codes_tried(thr_tx) * (span + 1);
    int total = (codes_tried(thr_tx) + codes_tried(thr_rx)) * (span + 1);
    int n = 0;
    logic [CODE_W-1:0] old_tx = tx_code, old_rx = rx_code;
    logic old_te = tx_err, old_re = rx_err;
    @(negedge clk);
    start_i = 1'b0;
    check(busy == 1'b1 && drive_code == 5'd31 && replica_sel == 1'b0, "R2",
          "busy/code after start", int'(drive_code), 31);
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (poke_start) start_i = (n == 3);
      if (n == tx_edge)
        check(replica_sel == 1'b1 && drive_code == 5'd31, "R4",
              "receive reload code", int'(drive_code), 31);
      if (done) break;
      if (tx_code != old_tx || rx_code != old_rx || tx_err != old_te || rx_err != old_re) begin
        check(1'b0, "R7", "stored results moved before done", int'(tx_code), int'(old_tx));
        old_tx = tx_code; old_rx = rx_code; old_te = tx_err; old_re = rx_err;
      end
      if (n > 5000) begin
        check(1'b0, "R5", "done never arrived", n, total);
        return;
      end
    end
    start_i = 1'b0;
    check(n == total, "R5", "done edge", n, total);
    check(busy == 1'b0, "R5", "busy at done", int'(busy), 0);
    check(int'(tx_code) == exp_code(thr_tx), "R4", "tx code", int'(tx_code), exp_code(thr_tx));
    check(int'(rx_code) == exp_code(thr_rx), "R5", "rx code", int'(rx_code), exp_code(thr_rx));
    check(tx_err == (thr_tx < 0), "R6", "tx err", int'(tx_err), int'(thr_tx < 0));
    check(rx_err == (thr_rx < 0), "R6", "rx err", int'(rx_err), int'(thr_rx < 0));
  endtask

  task automatic one_shot(int ttx, int trx, int s, bit poke);
    @(negedge clk);
    thr_tx = ttx; thr_rx = trx; settle_i = SETTLE_W'(s);
    start_i = 1'b1;
    @(posedge clk);
    measure_sweep(s, poke);
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R8", "extra sweep after poke", int'(busy), 0);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v = 32'd1234;
    void'($urandom(seed_v));
    repeat (3) @(negedge clk);
    // R1 reset values
    check(drive_code == 5'd31 && replica_sel == 1'b0 && busy == 1'b0 && done == 1'b0,
          "R1", "control reset", int'(drive_code), 31);
    check(tx_code == 0 && rx_code == 0 && tx_err == 0 && rx_err == 0,
          "R1", "result reset", int'(tx_code), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && drive_code == 5'd31, "R1", "idle without request", int'(busy), 0);

    // Directed corners
    one_shot(31, 31, 4, 1'b0);   // R4 immediate match on both replicas
    one_shot(20, 7, 0, 1'b0);    // R3 settle below floor acts as 2
    one_shot(12, 0, 1, 1'b0);    // R6 match exactly at floor code: no error
    one_shot(-1, 5, 3, 1'b0);    // R6 tx reaches floor unmatched
    one_shot(9, -1, 2, 1'b1);    // R8 start poked mid-sweep
    one_shot(-1, -1, 2, 1'b0);   // R6 both unmatched

    // Constrained random
    for (int i = 0; i < 20; i++) begin
      int a = int'($urandom % 33) - 1;
      int b = int'($urandom % 33) - 1;
      int s = int'($urandom % 6);
      one_shot(a, b, s, (i % 4) == 0);
    end

    // R9 continuous mode
    @(negedge clk);
    thr_tx = 25; thr_rx = 18; settle_i = 8'd3;
    cont_i = 1'b1;
    @(posedge clk);
    measure_sweep(3, 1'b0);
    thr_tx = 3; thr_rx = 29;
    @(posedge clk);   // R9 restart on the edge after done
    measure_sweep(3, 1'b0);
    cont_i = 1'b0;
    thr_tx = 14; thr_rx = 14;
    @(posedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R9", "idle after cont dropped", int'(busy), 0);
    repeat (5) begin
      @(negedge clk);
      check(busy == 1'b0 && done == 1'b0, "R9", "stays idle", int'(busy), 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule